// File: doc/BRIEF.md
# Header-Splitting Round-Robin Demultiplexer

This block sits behind a deserializer that delivers one 20-bit word per cycle. A marker flag travels with each word and tells header words apart from payload words. Header words are held in a small first-in, first-out store, and a host bus drains that store whenever it chooses. Payload words never enter the store. Each payload word is cut into two 10-bit halves, and each half is sent down its own lane. Each lane feeds nine downstream consumers, and a one-hot write strobe picks exactly one of them. Successive payload words go to successive consumers in a fixed rotation, so each consumer takes one ninth of the payload word rate.

Both lanes use one rotation position. A small state machine tracks where the stream is within an event, using three states:

- `ST_IDLE` is the state after reset, before any word has arrived.
- `ST_HEAD` means header words are arriving.
- `ST_BODY` means payload words are arriving.

The machine has three named transitions:

- `T_OPEN` is a header word seen in `ST_IDLE` or `ST_BODY`. It moves the machine to `ST_HEAD`, and it marks the start of an event, which clears the rotation to consumer 0.
- `T_FILL` is a payload word seen in any state. It moves the machine to `ST_BODY`.
- `T_STAY` covers every other case: a header word in `ST_HEAD`, or a cycle with no valid word. The machine keeps its current state.

Top module: `hdr_split_demux`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both strobe buses are zero, the header store reports empty and not full, and the overflow flag is low.
- R2: A payload word accepted on a clock edge appears on the lanes after that edge. Input bits [19:10] go to lane A and bits [9:0] go to lane B.
- R3: In the cycle after each accepted payload word, each lane's 9-bit strobe has exactly one bit set, and both lanes show the same bit. Bit k selects consumer k. In the cycle after a header word or a cycle with no valid word, both strobes are zero.
- R4: Each payload word moves the rotation forward by one consumer, and the rotation wraps from consumer 8 back to 0. Cycles with no valid word leave the rotation where it is.
- R5: A header word never changes the lane data and never raises a strobe.
- R6: The first header word after any payload word marks the start of an event. The next payload word after it goes to consumer 0.
- R7: The header store returns words in the order they arrived. The output `hdr_data` shows the oldest stored word whenever the store is not empty, and `hdr_rd` removes that word.
- R8: The store holds 16 words. `hdr_full` is high at 16 words and `hdr_empty` is high at 0 words.
- R9: A header word that arrives while the store is full is discarded. It sets `hdr_ovf`, which stays high until reset, and the stored contents are not changed.
- R10: Asserting `hdr_rd` while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_hdr | input | 1 | Input word is a header word |
| in_data | input | 20 | Deserialized word |
| hdr_rd | input | 1 | Host pops the oldest header word |
| hdr_data | output | 20 | Oldest stored header word |
| hdr_full | output | 1 | Header store holds 16 words |
| hdr_empty | output | 1 | Header store holds no words |
| hdr_ovf | output | 1 | Sticky flag: a header word was dropped |
| lane_a_data | output | 10 | Upper half of the last payload word |
| lane_a_stb | output | 9 | One-hot write strobe for lane A |
| lane_b_data | output | 10 | Lower half of the last payload word |
| lane_b_stb | output | 9 | One-hot write strobe for lane B |

## Verification
A wrong rotation position shows up on the strobe buses one cycle after the next payload word. If the position was not cleared at the start of an event, the first payload word strobes some consumer other than 0. A position that drifts during idle or header cycles shows up as a rotation that skips a consumer. A header store pointer or count that is off shows up on `hdr_data` or on the full and empty flags at the next push or pop. A lost overflow flag shows up in the cycle after the dropped header word.

// File: rtl/hdr_demux_pkg.sv
package hdr_demux_pkg;
    localparam int WORD_W     = 20;
    localparam int N_LANE     = 2;
    localparam int HALF_W     = WORD_W / N_LANE;
    localparam int N_DEST     = 9;
    localparam int FIFO_DEPTH = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } demux_state_t;
endpackage

// File: rtl/hdr_store.sv
module hdr_store #(
    parameter int W     = 20,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
            if (wr_en && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rot_ctr.sv
module rot_ctr #(
    parameter int N_DEST = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [N_DEST-1:0] sel_oh
);
    localparam int IW = $clog2(N_DEST);

    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            idx <= '0;
        else if (adv)
            idx <= (idx == IW'(N_DEST - 1)) ? '0 : idx + 1'b1;
    end

    for (genvar g = 0; g < N_DEST; g++) begin : g_dec
        assign sel_oh[g] = (idx == IW'(g));
    end
endmodule

// File: rtl/demux_lane.sv
module demux_lane #(
    parameter int HALF_W = 10,
    parameter int N_DEST = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [HALF_W-1:0] half,
    input  logic [N_DEST-1:0] sel_oh,
    output logic [HALF_W-1:0] data_q,
    output logic [N_DEST-1:0] stb_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stb_q  <= '0;
        end else begin
            stb_q <= go ? sel_oh : '0;
            if (go) data_q <= half;
        end
    end
endmodule

// File: rtl/hdr_split_demux.sv
module hdr_split_demux
    import hdr_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hdr,
    input  logic [WORD_W-1:0] in_data,
    input  logic              hdr_rd,
    output logic [WORD_W-1:0] hdr_data,
    output logic              hdr_full,
    output logic              hdr_empty,
    output logic              hdr_ovf,
    output logic [HALF_W-1:0] lane_a_data,
    output logic [N_DEST-1:0] lane_a_stb,
    output logic [HALF_W-1:0] lane_b_data,
    output logic [N_DEST-1:0] lane_b_stb
);
    demux_state_t state, state_nx;
    logic hdr_wr, pay_go, rot_clr;
    logic [N_DEST-1:0] sel_oh;
    logic [N_LANE-1:0][HALF_W-1:0] lane_dq;
    logic [N_LANE-1:0][N_DEST-1:0] lane_sq;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HEAD, ST_BODY: begin
                if (in_valid && in_hdr)       state_nx = ST_HEAD;  // T_OPEN / T_STAY
                else if (in_valid && !in_hdr) state_nx = ST_BODY;  // T_FILL
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        hdr_wr  = 1'b0;
        pay_go  = 1'b0;
        rot_clr = 1'b0;
        unique case (state)
            ST_HEAD: begin
                hdr_wr = in_valid && in_hdr;
                pay_go = in_valid && !in_hdr;
            end
            ST_IDLE, ST_BODY: begin
                hdr_wr  = in_valid && in_hdr;
                rot_clr = in_valid && in_hdr;   // T_OPEN: event start
                pay_go  = in_valid && !in_hdr;
            end
            default: ;
        endcase
    end

    hdr_store #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(hdr_wr), .wr_data(in_data),
        .rd_en(hdr_rd), .rd_data(hdr_data), .full(hdr_full),
        .empty(hdr_empty), .ovf(hdr_ovf)
    );

    rot_ctr #(.N_DEST(N_DEST)) u_rot (
        .clk(clk), .rst_n(rst_n), .clr(rot_clr), .adv(pay_go), .sel_oh(sel_oh)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        demux_lane #(.HALF_W(HALF_W), .N_DEST(N_DEST)) u_lane (
            .clk(clk), .rst_n(rst_n), .go(pay_go),
            .half(in_data[(N_LANE-g)*HALF_W-1 -: HALF_W]),
            .sel_oh(sel_oh), .data_q(lane_dq[g]), .stb_q(lane_sq[g])
        );
    end

    assign lane_a_data = lane_dq[0];
    assign lane_a_stb  = lane_sq[0];
    assign lane_b_data = lane_dq[1];
    assign lane_b_stb  = lane_sq[1];
endmodule

// File: rtl/hdr_demux_chk.sv
module hdr_demux_chk
    import hdr_demux_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_hdr,
    input logic [WORD_W-1:0] in_data,
    input logic              hdr_rd,
    input logic [WORD_W-1:0] hdr_data,
    input logic              hdr_full,
    input logic              hdr_empty,
    input logic              hdr_ovf,
    input logic [HALF_W-1:0] lane_a_data,
    input logic [N_DEST-1:0] lane_a_stb,
    input logic [HALF_W-1:0] lane_b_data,
    input logic [N_DEST-1:0] lane_b_stb
);
    p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hdr) |=> ($onehot(lane_a_stb) && lane_a_stb == lane_b_stb));

    p_stb_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !in_hdr) |=> (lane_a_stb == '0 && lane_b_stb == '0));

    p_lane_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hdr) |=> (lane_a_data == $past(in_data[WORD_W-1:HALF_W])
                                   && lane_b_data == $past(in_data[HALF_W-1:0])));

    p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a_stb != '0 && in_valid && !in_hdr)
        |=> lane_a_stb == {$past(lane_a_stb[N_DEST-2:0]), $past(lane_a_stb[N_DEST-1])});

    p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hdr) |=> ($stable(lane_a_data) && $stable(lane_b_data)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ovf |=> hdr_ovf);

    p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_full && hdr_empty));
endmodule

bind hdr_split_demux hdr_demux_chk u_chk (.*);

// File: tb/tb_hdr_split_demux.sv
module tb_hdr_split_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_hdr = 1'b0;
    logic [19:0] in_data = '0;
    logic        hdr_rd = 1'b0;
    logic [19:0] hdr_data;
    logic        hdr_full, hdr_empty, hdr_ovf;
    logic [9:0]  lane_a_data, lane_b_data;
    logic [8:0]  lane_a_stb, lane_b_stb;

    int total = 0;
    int bad = 0;
    int exp_idx = 0;
    bit done = 1'b0;
    logic [19:0] q[$];

    always #5 clk = ~clk;

    hdr_split_demux dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word at a negedge, return at the next negedge
    task automatic put(bit hdr, logic [19:0] d);
        in_valid = 1'b1; in_hdr = hdr; in_data = d;
        if (hdr) begin
            if (q.size() < 16) q.push_back(d);
            exp_idx = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0; in_hdr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pay_chk(logic [19:0] d);
        put(1'b0, d);
        chk("R2 lane A", 32'(lane_a_data), 32'(d[19:10]));
        chk("R2 lane B", 32'(lane_b_data), 32'(d[9:0]));
        chk("R3/R4 strobe A", 32'(lane_a_stb), 32'(9'b1 << exp_idx));
        chk("R3 strobe B", 32'(lane_b_stb), 32'(9'b1 << exp_idx));
        exp_idx = (exp_idx + 1) % 9;
    endtask

    task automatic pop_chk();
        chk("R7 order", 32'(hdr_data), 32'(q[0]));
        void'(q.pop_front());
        in_valid = 1'b0;
        hdr_rd = 1'b1;
        @(negedge clk);
        hdr_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 strobe A", 32'(lane_a_stb), 0);
        chk("R1 strobe B", 32'(lane_b_stb), 0);
        chk("R1 empty", 32'(hdr_empty), 1);
        chk("R1 full", 32'(hdr_full), 0);
        chk("R1 ovf", 32'(hdr_ovf), 0);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 20; i++) pay_chk(20'(i * 40503 + 17));
        idle();
        chk("R3 idle strobe", 32'(lane_a_stb | lane_b_stb), 0);
        idle();
        pay_chk(20'hABCDE);   // R4 rotation held across idle
        pay_chk(20'h00FFF);
    endtask

    task automatic t_header_mid();
        logic [9:0] a_prev, b_prev;
        a_prev = lane_a_data; b_prev = lane_b_data;
        put(1'b1, 20'h5A5A5);
        chk("R5 no strobe", 32'(lane_a_stb | lane_b_stb), 0);
        chk("R5 lane A held", 32'(lane_a_data), 32'(a_prev));
        chk("R5 lane B held", 32'(lane_b_data), 32'(b_prev));
        put(1'b1, 20'h12345);
        chk("R5 second header", 32'(lane_a_stb), 0);
        pay_chk(20'h33333);   // R6 must hit consumer 0
        chk("R6 restarted", 32'(exp_idx), 1);
        pay_chk(20'h44444);
    endtask

    task automatic t_fifo();
        idle();
        while (q.size() > 0) pop_chk();
        chk("R8 empty after drain", 32'(hdr_empty), 1);
        // R10: read on empty
        hdr_rd = 1'b1; @(negedge clk); hdr_rd = 1'b0;
        chk("R10 still empty", 32'(hdr_empty), 1);
        put(1'b1, 20'hC0DE1);
        idle();
        chk("R10 not empty", 32'(hdr_empty), 0);
        chk("R10 data", 32'(hdr_data), 32'h0C0DE1);
        for (int i = 1; i < 16; i++) put(1'b1, 20'(i * 4099 + 3));
        idle();
        chk("R8 full", 32'(hdr_full), 1);
        chk("R9 ovf low", 32'(hdr_ovf), 0);
        put(1'b1, 20'hFFFFF);
        chk("R9 ovf set", 32'(hdr_ovf), 1);
        idle();
        chk("R9 ovf sticky", 32'(hdr_ovf), 1);
        pay_chk(20'h76543);   // R6 after header burst
        idle();
        while (q.size() > 0) pop_chk();
        chk("R9 dropped word absent", 32'(hdr_empty), 1);
        chk("R9 ovf kept", 32'(hdr_ovf), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_header_mid();
        t_fifo();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule